// File: doc/BRIEF.md
# Coprocessor Instruction Trap Selector

This block sits on the CPU side of a CPU/floating-point coprocessor pair. It runs once for each instruction that the front end dispatches. It looks at the instruction's decoded class, the two control-register bits that say whether coprocessor work must be emulated in software or whether the coprocessor context belongs to another task, and the coprocessor's pending-error line. From these it decides whether the instruction may proceed or must trap, and which trap vector applies.

There are two trap vectors. Vector 7 means the coprocessor is unavailable: emulation is required, or the context is stale after a task switch. Vector 16 means that an earlier coprocessor instruction left an unmasked floating-point exception pending. The instruction classes are treated differently. The no-wait control forms (initialize, clear exceptions, store status, store environment, save state) must run even while an error is pending, so that a handler can inspect and clear it. A WAIT does no coprocessor arithmetic, so it ignores the emulate bit. When both vectors apply, the unavailable trap wins, so that no context belonging to another task is touched.

The decision is registered. The result appears as a one-cycle strobe together with an 8-bit vector in the cycle after the dispatch.

Top module: `cop_trap_sel`

## Requirements
- R1: A dispatched escape-type instruction (class 1 plain escape, or classes 3..7 no-wait forms) with the emulate bit set produces trap vector 7.
- R2: With the task-switched bit set, any dispatched class 1 (escape), class 2 (WAIT) or class 3..7 (no-wait form) produces trap vector 7.
- R3: A dispatched WAIT (class 2) with the emulate bit set and the task-switched bit clear does not produce vector 7. It traps with vector 16 if the error line is high and otherwise proceeds without a trap.
- R4: A dispatched class 1 escape or class 2 WAIT with the error line high, and with no vector 7 condition, produces trap vector 16.
- R5: The no-wait forms (classes 3..7) never produce vector 16. With the error line high and no vector 7 condition they proceed without a trap.
- R6: When a vector 7 condition and a pending error occur together, the vector is 7.
- R7: Class 0 (not a coprocessor instruction) never traps, and a cycle without a dispatch never traps.
- R8: trap_valid is high only in the cycle directly after a trapping dispatch, for exactly one cycle per dispatch. trap_vector is 0 whenever trap_valid is low.
- R9: An instruction that trapped with vector 16 proceeds without a trap when it is dispatched again after the error line has dropped, provided the control bits are clear.
- R10: While reset is high, and in the first cycle after it, trap_valid and trap_vector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch strobe, one cycle per instruction |
| disp_class | input | 3 | Decoded class: 0 none, 1 escape, 2 WAIT, 3 init, 4 clear exceptions, 5 store status, 6 store environment, 7 save |
| cr_emulate | input | 1 | Control bit: coprocessor instructions are emulated in software |
| cr_task_sw | input | 1 | Control bit: a task switch happened since the coprocessor context was last saved |
| cop_err | input | 1 | Coprocessor reports an unmasked exception pending |
| trap_valid | output | 1 | One-cycle strobe: the previous dispatch traps |
| trap_vector | output | 8 | Trap vector number (7 or 16), 0 when trap_valid is low |

## Verification
The bound checker tests every cycle that trap_valid only follows a dispatch, that the vector is zero when no trap is flagged, and that a dispatch under the emulate or task-switched bit yields vector 7 one cycle later. It also checks, on every cycle, that WAIT with only the emulate bit set and the no-wait forms never produce the wrong vector, and that class 0 and idle cycles stay silent. The bench scenarios are needed for the rest: the full cross product of class, control bits and error line against an independent model, back-to-back dispatches, and the restart sequence in which a trapped instruction is reissued after the error clears.

// File: rtl/cop_trap_pkg.sv
package cop_trap_pkg;

  localparam int CLS_W = 3;
  localparam int VEC_W = 8;

  // Instruction classes as delivered by the decoder
  typedef enum logic [CLS_W-1:0] {
    CLS_NONE     = 3'd0,
    CLS_ESC      = 3'd1,
    CLS_WAIT     = 3'd2,
    CLS_NW_INIT  = 3'd3,
    CLS_NW_CLEX  = 3'd4,
    CLS_NW_STSW  = 3'd5,
    CLS_NW_STENV = 3'd6,
    CLS_NW_SAVE  = 3'd7
  } cop_cls_e;

  // Per-class trap sensitivity
  typedef struct packed {
    logic is_cop;     // any coprocessor-related instruction
    logic em_sens;    // emulate bit can trap it
    logic ts_sens;    // task-switched bit can trap it
    logic err_sens;   // pending error can trap it
  } cls_attr_t;

endpackage

// File: rtl/cop_cls_decode.sv
module cop_cls_decode
  import cop_trap_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output cls_attr_t        attr
);

  always_comb begin
    attr = '0;
    case (cls)
      CLS_ESC: begin
        attr.is_cop   = 1'b1;
        attr.em_sens  = 1'b1;
        attr.ts_sens  = 1'b1;
        attr.err_sens = 1'b1;
      end
      CLS_WAIT: begin
        attr.is_cop   = 1'b1;
        attr.ts_sens  = 1'b1;
        attr.err_sens = 1'b1;
      end
      CLS_NW_INIT, CLS_NW_CLEX, CLS_NW_STSW, CLS_NW_STENV, CLS_NW_SAVE: begin
        attr.is_cop   = 1'b1;
        attr.em_sens  = 1'b1;
        attr.ts_sens  = 1'b1;
      end
      default: attr = '0;
    endcase
  end

endmodule

// File: rtl/cop_trap_rules.sv
module cop_trap_rules
  import cop_trap_pkg::*;
#(
  parameter int VW          = VEC_W,
  parameter int VEC_UNAVAIL = 7,
  parameter int VEC_FPERR   = 16
) (
  input  logic          valid,
  input  cls_attr_t     attr,
  input  logic          emulate,
  input  logic          task_sw,
  input  logic          err,
  output logic          take,
  output logic [VW-1:0] vec
);

  logic hit_unavail;
  logic hit_fperr;

  assign hit_unavail = valid && attr.is_cop &&
                       ((attr.em_sens && emulate) || (attr.ts_sens && task_sw));
  assign hit_fperr   = valid && attr.is_cop && attr.err_sens && err;

  // Unavailable trap has priority over the pending-error trap
  always_comb begin
    take = 1'b0;
    vec  = '0;
    if (hit_unavail) begin
      take = 1'b1;
      vec  = VW'(VEC_UNAVAIL);
    end else if (hit_fperr) begin
      take = 1'b1;
      vec  = VW'(VEC_FPERR);
    end
  end

endmodule

// File: rtl/cop_trap_sel.sv
module cop_trap_sel
  import cop_trap_pkg::*;
#(
  parameter int VW          = VEC_W,
  parameter int CW          = CLS_W,
  parameter int VEC_UNAVAIL = 7,
  parameter int VEC_FPERR   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          disp_valid,
  input  logic [CW-1:0] disp_class,
  input  logic          cr_emulate,
  input  logic          cr_task_sw,
  input  logic          cop_err,
  output logic          trap_valid,
  output logic [VW-1:0] trap_vector
);

  cls_attr_t     attr;
  logic          take_d;
  logic [VW-1:0] vec_d;

  cop_cls_decode u_dec (
    .cls  (CLS_W'(disp_class)),
    .attr (attr)
  );

  cop_trap_rules #(
    .VW          (VW),
    .VEC_UNAVAIL (VEC_UNAVAIL),
    .VEC_FPERR   (VEC_FPERR)
  ) u_rules (
    .valid   (disp_valid),
    .attr    (attr),
    .emulate (cr_emulate),
    .task_sw (cr_task_sw),
    .err     (cop_err),
    .take    (take_d),
    .vec     (vec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid  <= 1'b0;
      trap_vector <= '0;
    end else begin
      trap_valid  <= take_d;
      trap_vector <= vec_d;
    end
  end

endmodule

// File: rtl/cop_trap_sel_chk.sv
module cop_trap_sel_chk
  import cop_trap_pkg::*;
#(
  parameter int VW          = VEC_W,
  parameter int CW          = CLS_W,
  parameter int VEC_UNAVAIL = 7,
  parameter int VEC_FPERR   = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          disp_valid,
  input logic [CW-1:0] disp_class,
  input logic          cr_emulate,
  input logic          cr_task_sw,
  input logic          cop_err,
  input logic          trap_valid,
  input logic [VW-1:0] trap_vector
);

  logic is_nowait;
  assign is_nowait = (disp_class >= CW'(3));

  // R8: a strobe only follows a dispatch
  p_strobe_after_dispatch_r8: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> $past(disp_valid));

  // R8: quiet vector when no trap
  p_vector_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |-> (trap_vector == '0));

  // R1 / R6: escape-type with emulate set gives vector 7
  p_emulate_unavail_r1: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && (disp_class == CW'(1) || is_nowait) && cr_emulate)
      |=> (trap_valid && trap_vector == VW'(VEC_UNAVAIL)));

  // R2 / R6: task-switched gives vector 7 for every coprocessor class
  p_tasksw_unavail_r2: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_class != '0 && cr_task_sw)
      |=> (trap_valid && trap_vector == VW'(VEC_UNAVAIL)));

  // R3: WAIT ignores the emulate bit
  p_wait_no_emulate_r3: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_class == CW'(2) && cr_emulate && !cr_task_sw)
      |=> (trap_vector != VW'(VEC_UNAVAIL)));

  // R5: no-wait forms never see the error trap
  p_nowait_no_fperr_r5: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && is_nowait) |=> (trap_vector != VW'(VEC_FPERR)));

  // R7: class 0 and idle cycles never trap
  p_noncop_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (!disp_valid || disp_class == '0) |=> !trap_valid);

endmodule

bind cop_trap_sel cop_trap_sel_chk #(
  .VW          (VW),
  .CW          (CW),
  .VEC_UNAVAIL (VEC_UNAVAIL),
  .VEC_FPERR   (VEC_FPERR)
) u_chk (.*);

// File: tb/cop_trap_sel_tb.sv
module cop_trap_sel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disp_valid = 1'b0;
  logic [2:0] disp_class = 3'd0;
  logic       cr_emulate = 1'b0;
  logic       cr_task_sw = 1'b0;
  logic       cop_err = 1'b0;
  logic       trap_valid;
  logic [7:0] trap_vector;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;
  bit  summary_done = 1'b0;

  typedef struct {
    logic       v;
    logic [7:0] vec;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_trap_sel u_dut (
    .clk         (clk),
    .rst         (rst),
    .disp_valid  (disp_valid),
    .disp_class  (disp_class),
    .cr_emulate  (cr_emulate),
    .cr_task_sw  (cr_task_sw),
    .cop_err     (cop_err),
    .trap_valid  (trap_valid),
    .trap_vector (trap_vector)
  );

  // Reference from the requirements
  function automatic exp_t model(logic v, logic [2:0] c, logic em, logic ts, logic er);
    exp_t e;
    logic unav;
    e.v = 1'b0; e.vec = 8'd0; e.tag = "R7";
    if (!v || c == 3'd0) return e;
    unav = (c != 3'd2 && em) || ts;
    if (unav) begin
      e.v = 1'b1; e.vec = 8'd7;
      e.tag = (er) ? "R6" : (ts ? "R2" : "R1");
    end else if (er && (c == 3'd1 || c == 3'd2)) begin
      e.v = 1'b1; e.vec = 8'd16;
      e.tag = (c == 3'd2 && em) ? "R3" : "R4";
    end else begin
      e.tag = (c >= 3'd3) ? "R5" : ((c == 3'd2 && em) ? "R3" : "R8");
    end
    return e;
  endfunction

  task automatic check(string tag, logic av, logic [7:0] avec, logic ev, logic [7:0] evec);
    n_checks++;
    if (av !== ev || avec !== evec) begin
      n_fails++;
      $display("FAIL %s: got valid=%0b vector=%0d, expected valid=%0b vector=%0d",
               tag, av, avec, ev, evec);
    end
  endtask

  // Driver: one dispatch per cycle
  task automatic drive(logic v, logic [2:0] c, logic em, logic ts, logic er, string tag_override = "");
    exp_t e;
    @(negedge clk);
    disp_valid = v; disp_class = c;
    cr_emulate = em; cr_task_sw = ts; cop_err = er;
    e = model(v, c, em, ts, er);
    if (tag_override != "") e.tag = tag_override;
    sb_q.push_back(e);
  endtask

  // Monitor: compares each result a quarter period after its edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, trap_valid, trap_vector, e.v, e.vec);
    end
  end

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got running, expected finished");
      finish_run();
    end
  end

  initial begin
    // R10: reset state, with a dispatch held that would otherwise trap
    disp_valid = 1'b1; disp_class = 3'd1; cr_emulate = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R10", trap_valid, trap_vector, 1'b0, 8'd0);
    @(negedge clk);
    disp_valid = 1'b0; cr_emulate = 1'b0;
    rst = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R10", trap_valid, trap_vector, 1'b0, 8'd0);

    // Full cross product, back to back (R1..R8)
    for (int i = 0; i < 128; i++) begin
      drive(i[6], i[2:0], i[3], i[4], i[5]);
    end

    // R8: a trap followed by idle cycles gives a single pulse
    drive(1'b1, 3'd1, 1'b1, 1'b0, 1'b0, "R8");
    drive(1'b0, 3'd1, 1'b1, 1'b0, 1'b0, "R8");
    drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R8");

    // R9: error trap, error clears, the same instruction is reissued
    drive(1'b1, 3'd1, 1'b0, 1'b0, 1'b1, "R9");
    drive(1'b1, 3'd4, 1'b0, 1'b0, 1'b1, "R9");
    drive(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, "R9");
    drive(1'b1, 3'd2, 1'b0, 1'b0, 1'b1, "R9");
    drive(1'b1, 3'd2, 1'b0, 1'b0, 1'b0, "R9");

    // R7: non-coprocessor class under every condition
    drive(1'b1, 3'd0, 1'b1, 1'b1, 1'b1, "R7");
    drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_fails++;
      $display("FAIL R8: got %0d pending results, expected 0", sb_q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule